// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Hazard Unit

This block resolves data hazards for a five-stage, in-order, 32-bit integer pipeline (fetch, decode, execute, memory, writeback). It sits across the decode and execute stages and holds the decode-to-execute operand register. In decode it zeroes reads of register 0, and it replaces a register-file read with the writeback value when writeback is writing that same register in the same cycle. It also detects a load in execute whose result the decoding instruction needs. When that happens it holds fetch and decode and loads a bubble into execute.

In execute, each source register is re-resolved against the instructions now in the memory and writeback stages. Memory wins over writeback, and a load in the memory stage is never used as a source. After this forwarding, the first ALU operand is chosen from the forwarded register value, zero or the program counter. The second ALU operand is the forwarded register value or the immediate. The forwarded second register value is also driven out as store data. The ALU, the memories, the branch logic and instruction decoding are outside this block.

Top module: `fwd_hazard_unit`

## Requirements
- R1: After reset the execute slot is a bubble: exBubble=1, exRegWrite=0, exIsLoad=0, exRd=0, and exOpA, exOpB and exStoreData are 0.
- R2: In decode, when wbRegWrite=1, wbRd is nonzero and wbRd equals idRs1 (or idRs2), the value captured for that source is wbData instead of the register-file read.
- R3: A source index of 0 always yields 0, whatever the register-file read data. A destination index of 0 in the memory or writeback stage is never forwarded or bypassed.
- R4: In execute, a source whose index equals memRd, with memRegWrite=1, memIsLoad=0 and memRd nonzero, takes memResult. Its value is visible on the outputs in the same cycle.
- R5: In execute, a source not served from memory whose index equals a nonzero wbRd with wbRegWrite=1 takes wbData.
- R6: When memory and writeback both match the same source, the memory result is used.
- R7: A load in the memory stage (memIsLoad=1) is never a forwarding source. The operand falls through to writeback or to the captured value.
- R8: idOpASel selects the first ALU operand: 0 = forwarded rs1, 1 = zero, 2 = PC, 3 = zero.
- R9: idOpBSel selects the second ALU operand: 0 = forwarded rs2, 1 = immediate. exStoreData is always the forwarded rs2 value.
- R10: holdFetch is 1 in the same cycle when execute holds a load with exRegWrite=1 and a nonzero exRd that equals idRs1 or idRs2.
- R11: In a cycle with holdFetch=1, the next edge loads a bubble (exBubble=1, exRegWrite=0, exIsLoad=0, exRd=0, operands 0). Otherwise it captures the decode fields with exBubble=0.
- R12: No stall is raised for a load in execute whose write enable is 0 or whose destination is register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idRs1 | input | 5 | Decode source index 1 |
| idRs2 | input | 5 | Decode source index 2 |
| idRd | input | 5 | Decode destination index |
| idRegWrite | input | 1 | Decode instruction writes a register |
| idIsLoad | input | 1 | Decode instruction is a load |
| idRfData1 | input | 32 | Register-file read for source 1 |
| idRfData2 | input | 32 | Register-file read for source 2 |
| idPc | input | 32 | PC of the decode instruction |
| idImm | input | 32 | Extended immediate of the decode instruction |
| idOpASel | input | 2 | First operand select (R8 encoding) |
| idOpBSel | input | 1 | Second operand select (R9 encoding) |
| memRd | input | 5 | Memory-stage destination index |
| memRegWrite | input | 1 | Memory-stage write enable |
| memIsLoad | input | 1 | Memory-stage instruction is a load |
| memResult | input | 32 | Memory-stage ALU result |
| wbRd | input | 5 | Writeback destination index |
| wbRegWrite | input | 1 | Writeback write enable |
| wbData | input | 32 | Writeback value |
| exOpA | output | 32 | First ALU operand |
| exOpB | output | 32 | Second ALU operand |
| exStoreData | output | 32 | Forwarded rs2 value for stores |
| exRd | output | 5 | Execute destination index |
| exRegWrite | output | 1 | Execute write enable |
| exIsLoad | output | 1 | Execute instruction is a load |
| exBubble | output | 1 | Execute slot holds a bubble |
| holdFetch | output | 1 | Hold PC and fetch-to-decode register |

## Verification
The hardest situation to reach is the full load-use sequence. A load must sit in execute with the consumer waiting in decode. The stall cycle must then put a bubble in execute while the held consumer stays put. One cycle later the load's data must arrive through writeback forwarding, not through the stale register read captured in decode. The stimulus drives a load into decode, then holds the consumer's decode inputs unchanged across the stall. It presents the load in the memory stage with a decoy result, and then in writeback with the true data. Other sequences put a load in the memory stage alongside a matching writeback, and loads with a cleared write enable or destination 0, so the R7 and R12 corners are reached.

// File: rtl/fwd_hazard_pkg.sv
package fwd_hazard_pkg;

  localparam int NSRC = 2;

  localparam logic [1:0] FWD_RF  = 2'd0;
  localparam logic [1:0] FWD_MEM = 2'd1;
  localparam logic [1:0] FWD_WB  = 2'd2;

  localparam logic [1:0] ASEL_REG  = 2'd0;
  localparam logic [1:0] ASEL_ZERO = 2'd1;
  localparam logic [1:0] ASEL_PC   = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic [NSRC-1:0]       bypass;  // decode: take writeback value
    logic [NSRC-1:0][1:0]  fwd;     // execute: forwarding source
    logic                  stall;   // load-use hazard
  } strobes_t;

endpackage

// File: rtl/fwd_hazard_ctrl.sv
module fwd_hazard_ctrl
  import fwd_hazard_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [NSRC-1:0][AW-1:0] idRs,
  input  logic [NSRC-1:0][AW-1:0] exRs,
  input  logic [AW-1:0]           exRd,
  input  logic                    exRegWrite,
  input  logic                    exIsLoad,
  input  logic [AW-1:0]           memRd,
  input  logic                    memRegWrite,
  input  logic                    memIsLoad,
  input  logic [AW-1:0]           wbRd,
  input  logic                    wbRegWrite,
  output strobes_t                strb
);

  logic wbLive, memLive, loadLive;
  logic [NSRC-1:0]      bypassVec;
  logic [NSRC-1:0]      hitVec;
  logic [NSRC-1:0][1:0] fwdVec;

  // a producer counts only if it writes a nonzero register
  assign wbLive   = wbRegWrite && (wbRd != '0);
  assign memLive  = memRegWrite && !memIsLoad && (memRd != '0);
  assign loadLive = exRegWrite && exIsLoad && (exRd != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign bypassVec[g] = wbLive && (wbRd == idRs[g]);
    assign hitVec[g]    = loadLive && (exRd == idRs[g]);
    assign fwdVec[g]    = (memLive && (memRd == exRs[g])) ? FWD_MEM :
                          (wbLive  && (wbRd  == exRs[g])) ? FWD_WB  : FWD_RF;
  end

  always_comb begin
    strb        = '0;
    strb.bypass = bypassVec;
    strb.fwd    = fwdVec;
    strb.stall  = |hitVec;
  end

endmodule

// File: rtl/fwd_hazard_dpath.sv
module fwd_hazard_dpath
  import fwd_hazard_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  strobes_t                  strb,
  input  logic [NSRC-1:0][AW-1:0]   idRs,
  input  logic [NSRC-1:0][XLEN-1:0] idRfData,
  input  logic [AW-1:0]             idRd,
  input  logic                      idRegWrite,
  input  logic                      idIsLoad,
  input  logic [XLEN-1:0]           idPc,
  input  logic [XLEN-1:0]           idImm,
  input  logic [1:0]                idOpASel,
  input  logic                      idOpBSel,
  input  logic [XLEN-1:0]           memResult,
  input  logic [XLEN-1:0]           wbData,
  output logic [NSRC-1:0][AW-1:0]   exRs,
  output logic [AW-1:0]             exRd,
  output logic                      exRegWrite,
  output logic                      exIsLoad,
  output logic                      exBubble,
  output logic [XLEN-1:0]           exOpA,
  output logic [XLEN-1:0]           exOpB,
  output logic [XLEN-1:0]           exStoreData
);

  logic [NSRC-1:0][XLEN-1:0] idVal;
  logic [NSRC-1:0][XLEN-1:0] exVal;
  logic [NSRC-1:0][XLEN-1:0] fwdVal;
  logic [XLEN-1:0]           exPc, exImm;
  logic [1:0]                exASel;
  logic                      exBSel;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    // decode read: register 0 is hard zero, then writeback bypass
    assign idVal[g] = (idRs[g] == '0) ? '0 :
                      strb.bypass[g]  ? wbData : idRfData[g];

    always_comb begin
      unique case (strb.fwd[g])
        FWD_MEM: fwdVal[g] = memResult;
        FWD_WB:  fwdVal[g] = wbData;
        default: fwdVal[g] = exVal[g];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exRs       <= '0;
      exVal      <= '0;
      exRd       <= '0;
      exRegWrite <= 1'b0;
      exIsLoad   <= 1'b0;
      exBubble   <= 1'b1;
      exPc       <= '0;
      exImm      <= '0;
      exASel     <= ASEL_REG;
      exBSel     <= 1'b0;
    end else if (strb.stall) begin
      exRs       <= '0;
      exVal      <= '0;
      exRd       <= '0;
      exRegWrite <= 1'b0;
      exIsLoad   <= 1'b0;
      exBubble   <= 1'b1;
      exPc       <= '0;
      exImm      <= '0;
      exASel     <= ASEL_REG;
      exBSel     <= 1'b0;
    end else begin
      exRs       <= idRs;
      exVal      <= idVal;
      exRd       <= idRd;
      exRegWrite <= idRegWrite;
      exIsLoad   <= idIsLoad;
      exBubble   <= 1'b0;
      exPc       <= idPc;
      exImm      <= idImm;
      exASel     <= idOpASel;
      exBSel     <= idOpBSel;
    end
  end

  always_comb begin
    unique case (exASel)
      ASEL_REG: exOpA = fwdVal[0];
      ASEL_PC:  exOpA = exPc;
      default:  exOpA = '0;
    endcase
  end

  assign exOpB       = exBSel ? exImm : fwdVal[1];
  assign exStoreData = fwdVal[1];

endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
  import fwd_hazard_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   idRs1,
  input  logic [AW-1:0]   idRs2,
  input  logic [AW-1:0]   idRd,
  input  logic            idRegWrite,
  input  logic            idIsLoad,
  input  logic [XLEN-1:0] idRfData1,
  input  logic [XLEN-1:0] idRfData2,
  input  logic [XLEN-1:0] idPc,
  input  logic [XLEN-1:0] idImm,
  input  logic [1:0]      idOpASel,
  input  logic            idOpBSel,
  input  logic [AW-1:0]   memRd,
  input  logic            memRegWrite,
  input  logic            memIsLoad,
  input  logic [XLEN-1:0] memResult,
  input  logic [AW-1:0]   wbRd,
  input  logic            wbRegWrite,
  input  logic [XLEN-1:0] wbData,
  output logic [XLEN-1:0] exOpA,
  output logic [XLEN-1:0] exOpB,
  output logic [XLEN-1:0] exStoreData,
  output logic [AW-1:0]   exRd,
  output logic            exRegWrite,
  output logic            exIsLoad,
  output logic            exBubble,
  output logic            holdFetch
);

  strobes_t                  strb;
  logic [NSRC-1:0][AW-1:0]   idRs;
  logic [NSRC-1:0][AW-1:0]   exRs;
  logic [NSRC-1:0][XLEN-1:0] idRfData;

  assign idRs     = {idRs2, idRs1};
  assign idRfData = {idRfData2, idRfData1};
  assign holdFetch = strb.stall;

  fwd_hazard_ctrl #(.AW(AW)) u_ctrl (
    .idRs        (idRs),
    .exRs        (exRs),
    .exRd        (exRd),
    .exRegWrite  (exRegWrite),
    .exIsLoad    (exIsLoad),
    .memRd       (memRd),
    .memRegWrite (memRegWrite),
    .memIsLoad   (memIsLoad),
    .wbRd        (wbRd),
    .wbRegWrite  (wbRegWrite),
    .strb        (strb)
  );

  fwd_hazard_dpath #(.XLEN(XLEN), .AW(AW)) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .idRs        (idRs),
    .idRfData    (idRfData),
    .idRd        (idRd),
    .idRegWrite  (idRegWrite),
    .idIsLoad    (idIsLoad),
    .idPc        (idPc),
    .idImm       (idImm),
    .idOpASel    (idOpASel),
    .idOpBSel    (idOpBSel),
    .memResult   (memResult),
    .wbData      (wbData),
    .exRs        (exRs),
    .exRd        (exRd),
    .exRegWrite  (exRegWrite),
    .exIsLoad    (exIsLoad),
    .exBubble    (exBubble),
    .exOpA       (exOpA),
    .exOpB       (exOpB),
    .exStoreData (exStoreData)
  );

endmodule

// File: rtl/fwd_hazard_unit_chk.sv
module fwd_hazard_unit_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] idRd,
  input logic          idRegWrite,
  input logic          idIsLoad,
  input logic [AW-1:0] exRd,
  input logic          exRegWrite,
  input logic          exIsLoad,
  input logic          exBubble,
  input logic          holdFetch
);

  // R10: a stall only arises from a live load in execute
  a_r10_stall_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    holdFetch |-> (exIsLoad && exRegWrite && exRd != '0));

  // R10: the bubble it inserts cannot stall again
  a_r10_no_double_stall: assert property (@(posedge clk) disable iff (!rst_n)
    holdFetch |=> !holdFetch);

  // R11: stall loads an empty execute slot
  a_r11_bubble_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    holdFetch |=> (exBubble && !exRegWrite && !exIsLoad && exRd == '0));

  // R11: otherwise decode fields advance
  a_r11_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !holdFetch |=> (!exBubble && exRd == $past(idRd) &&
                    exRegWrite == $past(idRegWrite) && exIsLoad == $past(idIsLoad)));

endmodule

bind fwd_hazard_unit fwd_hazard_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .idRd       (idRd),
  .idRegWrite (idRegWrite),
  .idIsLoad   (idIsLoad),
  .exRd       (exRd),
  .exRegWrite (exRegWrite),
  .exIsLoad   (exIsLoad),
  .exBubble   (exBubble),
  .holdFetch  (holdFetch)
);

// File: tb/fwd_hazard_unit_tb.sv
`timescale 1ns/1ps
module fwd_hazard_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  idRs1 = '0, idRs2 = '0, idRd = '0;
  logic        idRegWrite = 1'b0, idIsLoad = 1'b0;
  logic [31:0] idRfData1 = '0, idRfData2 = '0, idPc = '0, idImm = '0;
  logic [1:0]  idOpASel = '0;
  logic        idOpBSel = 1'b0;
  logic [4:0]  memRd = '0;
  logic        memRegWrite = 1'b0, memIsLoad = 1'b0;
  logic [31:0] memResult = '0;
  logic [4:0]  wbRd = '0;
  logic        wbRegWrite = 1'b0;
  logic [31:0] wbData = '0;
  logic [31:0] exOpA, exOpB, exStoreData;
  logic [4:0]  exRd;
  logic        exRegWrite, exIsLoad, exBubble, holdFetch;

  always #2 clk = ~clk;

  fwd_hazard_unit u_dut (.*);

  typedef struct {
    logic [31:0] a, b, sd;
    logic        hold, bub;
    logic [4:0]  rd;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int   nChecks = 0;
  int   nFails  = 0;
  bit   done    = 0;

  task automatic setId(input logic [4:0] rs1, rs2, rd, input logic rw, ld,
                       input logic [31:0] d1, d2, pc, imm,
                       input logic [1:0] asel, input logic bsel);
    idRs1 = rs1; idRs2 = rs2; idRd = rd; idRegWrite = rw; idIsLoad = ld;
    idRfData1 = d1; idRfData2 = d2; idPc = pc; idImm = imm;
    idOpASel = asel; idOpBSel = bsel;
  endtask

  task automatic setMem(input logic [4:0] rd, input logic rw, ld, input logic [31:0] res);
    memRd = rd; memRegWrite = rw; memIsLoad = ld; memResult = res;
  endtask

  task automatic setWb(input logic [4:0] rd, input logic rw, input logic [31:0] d);
    wbRd = rd; wbRegWrite = rw; wbData = d;
  endtask

  // driver side: open a cycle just after the edge, late stages idle
  task automatic nextCycle();
    @(posedge clk); #0.5;
    setMem(5'd0, 1'b0, 1'b0, 32'h0);
    setWb(5'd0, 1'b0, 32'h0);
  endtask

  task automatic push(input logic [31:0] a, b, sd, input logic hold, bub,
                      input logic [4:0] rd, input string tag);
    exp_t e;
    e.a = a; e.b = b; e.sd = sd; e.hold = hold; e.bub = bub; e.rd = rd; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: compare mid-cycle
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      nChecks++;
      if (exOpA !== e.a || exOpB !== e.b || exStoreData !== e.sd ||
          holdFetch !== e.hold || exBubble !== e.bub || exRd !== e.rd) begin
        nFails++;
        $display("FAIL %s: act a=%h b=%h sd=%h hold=%b bub=%b rd=%0d exp a=%h b=%h sd=%h hold=%b bub=%b rd=%0d",
                 e.tag, exOpA, exOpB, exStoreData, holdFetch, exBubble, exRd,
                 e.a, e.b, e.sd, e.hold, e.bub, e.rd);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;
    // c0: reset state; I1 enters decode
    setId(5'd1, 5'd2, 5'd5, 1, 0, 32'd100, 32'd200, 32'h40, 32'd4, 2'd0, 1'b0);
    push(32'h0, 32'h0, 32'h0, 0, 1, 5'd0, "R1 reset bubble");
    // c1: I1 in ex; wb writes x1 -> ex fwd (R5) and decode bypass for I2 (R2)
    nextCycle();
    setWb(5'd1, 1'b1, 32'hAAAA);
    setId(5'd1, 5'd2, 5'd6, 1, 0, 32'd111, 32'd222, 32'h44, 32'd0, 2'd0, 1'b0);
    push(32'hAAAA, 32'd200, 32'd200, 0, 0, 5'd5, "R5 wb fwd, R11 capture");
    // c2: I2 holds bypassed value
    nextCycle();
    setId(5'd3, 5'd4, 5'd7, 1, 0, 32'd7, 32'd8, 32'h48, 32'd0, 2'd0, 1'b0);
    push(32'hAAAA, 32'd222, 32'd222, 0, 0, 5'd6, "R2 decode bypass");
    // c3: mem fwd rs1, wb fwd rs2
    nextCycle();
    setMem(5'd3, 1'b1, 1'b0, 32'h333);
    setWb(5'd4, 1'b1, 32'h444);
    setId(5'd9, 5'd9, 5'd8, 1, 0, 32'd1, 32'd2, 32'h4C, 32'd0, 2'd0, 1'b0);
    push(32'h333, 32'h444, 32'h444, 0, 0, 5'd7, "R4 mem fwd / R5 wb fwd");
    // c4: both match -> memory wins
    nextCycle();
    setMem(5'd9, 1'b1, 1'b0, 32'h999);
    setWb(5'd9, 1'b1, 32'h888);
    setId(5'd10, 5'd11, 5'd9, 1, 0, 32'h10, 32'h11, 32'h50, 32'd0, 2'd0, 1'b0);
    push(32'h999, 32'h999, 32'h999, 0, 0, 5'd8, "R6 mem priority");
    // c5: load in mem skipped, wb used
    nextCycle();
    setMem(5'd10, 1'b1, 1'b1, 32'hDEAD);
    setWb(5'd10, 1'b1, 32'hBEEF);
    setId(5'd0, 5'd12, 5'd0, 1, 0, 32'h5555, 32'h12, 32'h54, 32'h77, 2'd0, 1'b1);
    push(32'hBEEF, 32'h11, 32'h11, 0, 0, 5'd9, "R7 load in mem not fwd");
    // c6: x0 source with x0 producers; opB immediate
    nextCycle();
    setMem(5'd0, 1'b1, 1'b0, 32'hF00);
    setWb(5'd0, 1'b1, 32'hF11);
    setId(5'd13, 5'd0, 5'd14, 1, 0, 32'h13, 32'h9, 32'h1000, 32'h20, 2'd2, 1'b1);
    push(32'h0, 32'h77, 32'h12, 0, 0, 5'd0, "R3 x0 zero / R9 imm");
    // c7: PC as opA, rs2=x0 reads zero
    nextCycle();
    setId(5'd15, 5'd16, 5'd17, 1, 0, 32'h15, 32'h16, 32'h58, 32'd0, 2'd1, 1'b0);
    push(32'h1000, 32'h20, 32'h0, 0, 0, 5'd14, "R8 pc select / R3");
    // c8: zero select
    nextCycle();
    setId(5'd15, 5'd16, 5'd0, 0, 0, 32'h15, 32'h16, 32'h5C, 32'd0, 2'd3, 1'b0);
    push(32'h0, 32'h16, 32'h16, 0, 0, 5'd17, "R8 zero select");
    // c9: select 3 -> zero; load L1 enters decode
    nextCycle();
    setId(5'd1, 5'd0, 5'd20, 1, 1, 32'h100, 32'h0, 32'h60, 32'd8, 2'd0, 1'b1);
    push(32'h0, 32'h16, 32'h16, 0, 0, 5'd0, "R8 select 3");
    // c10: L1 in ex, consumer of x20 in decode -> stall
    nextCycle();
    setId(5'd20, 5'd21, 5'd22, 1, 0, 32'h0, 32'h21, 32'h64, 32'd0, 2'd0, 1'b0);
    push(32'h100, 32'd8, 32'h0, 1, 0, 5'd20, "R10 load-use stall rs1");
    // c11: bubble in ex, consumer held, load in mem with decoy
    nextCycle();
    setMem(5'd20, 1'b1, 1'b1, 32'hBAD);
    push(32'h0, 32'h0, 32'h0, 0, 1, 5'd0, "R11 bubble inserted");
    // c12: consumer in ex, load data from wb
    nextCycle();
    setWb(5'd20, 1'b1, 32'h7777);
    setId(5'd0, 5'd0, 5'd23, 0, 1, 32'h0, 32'h0, 32'h68, 32'd0, 2'd0, 1'b0);
    push(32'h7777, 32'h21, 32'h21, 0, 0, 5'd22, "R5 load data via wb");
    // c13: load without write enable in ex; consumer of x23 -> no stall
    nextCycle();
    setId(5'd23, 5'd0, 5'd0, 1, 1, 32'h23, 32'h0, 32'h6C, 32'd0, 2'd0, 1'b0);
    push(32'h0, 32'h0, 32'h0, 0, 0, 5'd23, "R12 no stall rw=0");
    // c14: load to x0 in ex; consumer reads x0 -> no stall
    nextCycle();
    setId(5'd0, 5'd0, 5'd24, 1, 1, 32'h0, 32'h0, 32'h70, 32'd0, 2'd0, 1'b0);
    push(32'h23, 32'h0, 32'h0, 0, 0, 5'd0, "R12 no stall rd=x0");
    // c15: load to x24 in ex; consumer uses x24 as rs2 -> stall
    nextCycle();
    setId(5'd1, 5'd24, 5'd25, 1, 0, 32'h1, 32'h0, 32'h74, 32'd0, 2'd0, 1'b0);
    push(32'h0, 32'h0, 32'h0, 1, 0, 5'd24, "R10 load-use stall rs2");
    // c16: bubble
    nextCycle();
    push(32'h0, 32'h0, 32'h0, 0, 1, 5'd0, "R11 bubble after rs2 stall");
    nextCycle();
    wait (expQ.size() == 0);
    @(posedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: act timeout exp completion");
    end
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule